// File: doc/BRIEF.md
# Load/Store Effective-Address Memory Sequencer

This block carries out the data-movement part of a small 16-bit processor: the loads, the stores and the address-only instruction. A caller presents the instruction word, the already-incremented program counter and the two register operands the instruction may need, then pulses `start`. The sequencer forms the effective address and runs the memory accesses against one shared word-addressed memory. Each access holds its address and strobe until the memory answers with `memReady`. When the instruction produces a value, the sequencer writes it back to the register file. It finishes with a one-cycle `done`.

Two addressing families are supported. The first is program-counter relative, with a 9-bit signed displacement. The second is register based, with a 6-bit signed displacement. The indirect forms spend one extra read to fetch a pointer, and that pointer becomes the operand address. The address-only form returns the computed address without touching memory. Every register write-back also refreshes a three-flag sign indicator. Stores leave that indicator alone.

Top module: `ldst_seq`

## Requirements
- R1: After reset the block is idle with `memRd`, `memWr`, `regWe` and `done` low, and the flags read N=0, Z=1, P=0.
- R2: For opcodes 0010 (load), 1010 (indirect load), 0011 (store), 1011 (indirect store) and 1110 (address-only), the first address is `pcNext` plus `instr[8:0]` sign-extended to 16 bits. The destination or source register index is `instr[11:9]`.
- R3: For opcodes 0110 (register-based load) and 0111 (register-based store), the address is `baseVal` plus `instr[5:0]` sign-extended, giving a displacement from -32 to +31.
- R4: The indirect load and indirect store first read the word at the computed address. They then use that word as the address of the real read or write, so they make exactly two memory accesses.
- R5: The address-only opcode writes the computed address into register `instr[11:9]` with no memory access. `done` appears two cycles after the start edge.
- R6: A load writes the word read from memory into register `instr[11:9]` with a single `regWe` pulse.
- R7: A store writes `srcVal` to its target address, makes no register write, and leaves the flags unchanged.
- R8: On each register write the flags become N=bit 15 of the value, Z=value is zero, P=otherwise. Exactly one flag is set at any time.
- R9: A memory access keeps its address, write data and strobe steady until `memReady` is sampled high. `memRd` and `memWr` are never high together.
- R10: `done` is a single-cycle pulse after the last access or write-back. Any other opcode completes with `done` one cycle after the start edge, with no access and no write.
- R11: `start` is ignored while an instruction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the instruction on `instr` (taken only when idle) |
| instr | input | 16 | Instruction word |
| pcNext | input | 16 | Address of the following instruction |
| baseVal | input | 16 | Value of the base register named by `instr[8:6]` |
| srcVal | input | 16 | Value of the register named by `instr[11:9]` (store data) |
| memAddr | output | 16 | Memory word address |
| memWdata | output | 16 | Memory write data |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| memRdata | input | 16 | Memory read data, valid with `memReady` |
| memReady | input | 1 | Memory completes the current access |
| regWe | output | 1 | Register write-back enable |
| regIdx | output | 3 | Register write-back index |
| regData | output | 16 | Register write-back value |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagP | output | 1 | Positive flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions take three things for granted. `memReady` rises only while a strobe is high and stays high for one cycle. `memRdata` is valid in the cycle where `memReady` is high. The operand inputs need to be valid only at the start edge. The bench memory model honours this. It answers each strobe after a random wait of zero to two cycles and drops `memReady` the cycle after each completion. The bench changes `instr` and pulses `start` only between instructions, except in the directed case that probes R11.

// File: rtl/ldst_pkg.sv
`timescale 1ns/1ps
package ldst_pkg;
  localparam int OP_W    = 4;
  localparam int PCOFF_W = 9;
  localparam int BOFF_W  = 6;

  localparam logic [OP_W-1:0] OPC_LD  = 4'b0010;
  localparam logic [OP_W-1:0] OPC_LDI = 4'b1010;
  localparam logic [OP_W-1:0] OPC_LDR = 4'b0110;
  localparam logic [OP_W-1:0] OPC_LEA = 4'b1110;
  localparam logic [OP_W-1:0] OPC_ST  = 4'b0011;
  localparam logic [OP_W-1:0] OPC_STI = 4'b1011;
  localparam logic [OP_W-1:0] OPC_STR = 4'b0111;

  typedef enum logic [2:0] {
    S_IDLE, S_PTR, S_RD, S_WR, S_WB, S_DONE
  } seqState_t;

  typedef struct packed {
    logic capture;     // latch operands and effective address
    logic rdStb;       // memory read in progress
    logic wrStb;       // memory write in progress
    logic mdrFromMem;  // data word arrives
    logic marFromMem;  // pointer word arrives
    logic regWrite;    // register write-back
    logic wbAddr;      // write back the address instead of data
    logic doneStb;     // completion pulse
  } ctrlStrobes_t;
endpackage

// File: rtl/ldst_ctrl.sv
`timescale 1ns/1ps
module ldst_ctrl
  import ldst_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OP_W-1:0]   opcode,
  input  logic              memReady,
  output ctrlStrobes_t      strobes
);
  seqState_t state, nextState;
  logic indStore, isAddrOnly;

  always_comb begin
    nextState = state;
    case (state)
      S_IDLE: if (start) begin
        case (opcode)
          OPC_LD, OPC_LDR:  nextState = S_RD;
          OPC_LDI, OPC_STI: nextState = S_PTR;
          OPC_ST, OPC_STR:  nextState = S_WR;
          OPC_LEA:          nextState = S_WB;
          default:          nextState = S_DONE;
        endcase
      end
      S_PTR:  if (memReady) nextState = indStore ? S_WR : S_RD;
      S_RD:   if (memReady) nextState = S_WB;
      S_WR:   if (memReady) nextState = S_DONE;
      S_WB:   nextState = S_DONE;
      S_DONE: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      indStore   <= 1'b0;
      isAddrOnly <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_IDLE && start) begin
        indStore   <= (opcode == OPC_STI);
        isAddrOnly <= (opcode == OPC_LEA);
      end
    end
  end

  always_comb begin
    strobes            = '0;
    strobes.capture    = (state == S_IDLE) && start;
    strobes.rdStb      = (state == S_PTR) || (state == S_RD);
    strobes.wrStb      = (state == S_WR);
    strobes.mdrFromMem = (state == S_RD) && memReady;
    strobes.marFromMem = (state == S_PTR) && memReady;
    strobes.regWrite   = (state == S_WB);
    strobes.wbAddr     = isAddrOnly;
    strobes.doneStb    = (state == S_DONE);
  end

  // R10: completion lasts one cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doneStb |=> !strobes.doneStb);
  // R9: never read and write at once
  a_r9_rd_wr_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.rdStb && strobes.wrStb));
  // R7: a write access is never followed by a register write
  a_r7_store_no_wb: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrStb |=> !strobes.regWrite);
  // R11: a start during a busy cycle does not restart capture
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdStb |=> !strobes.capture);
endmodule

// File: rtl/ldst_dpath.sv
`timescale 1ns/1ps
module ldst_dpath
  import ldst_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] pcNext,
  input  logic [WORD_W-1:0] baseVal,
  input  logic [WORD_W-1:0] srcVal,
  input  logic [WORD_W-1:0] memRdata,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [IDX_W-1:0]  regIdx,
  output logic [WORD_W-1:0] regData,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagP
);
  localparam int REG_LSB = PCOFF_W;

  logic [WORD_W-1:0] mar, mdr, pcOff, baseOff, effAddr;
  logic [IDX_W-1:0]  dstIdx;
  logic [OP_W-1:0]   opcode;
  logic              useBase;

  assign opcode  = instr[WORD_W-1 -: OP_W];
  assign useBase = (opcode == OPC_LDR) || (opcode == OPC_STR);
  assign pcOff   = {{(WORD_W-PCOFF_W){instr[PCOFF_W-1]}}, instr[PCOFF_W-1:0]};
  assign baseOff = {{(WORD_W-BOFF_W){instr[BOFF_W-1]}}, instr[BOFF_W-1:0]};
  assign effAddr = useBase ? (baseVal + baseOff) : (pcNext + pcOff);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mar    <= '0;
      mdr    <= '0;
      dstIdx <= '0;
    end else begin
      if (strobes.capture) begin
        mar    <= effAddr;
        mdr    <= srcVal;
        dstIdx <= instr[REG_LSB +: IDX_W];
      end else if (strobes.marFromMem) begin
        mar <= memRdata;
      end else if (strobes.mdrFromMem) begin
        mdr <= memRdata;
      end
    end
  end

  assign memAddr  = mar;
  assign memWdata = mdr;
  assign regIdx   = dstIdx;
  assign regData  = strobes.wbAddr ? mar : mdr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagN <= 1'b0;
      flagZ <= 1'b1;
      flagP <= 1'b0;
    end else if (strobes.regWrite) begin
      flagN <= regData[WORD_W-1];
      flagZ <= (regData == '0);
      flagP <= !regData[WORD_W-1] && (regData != '0);
    end
  end

  // R8: exactly one flag set
  a_r8_flags_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $countones({flagN, flagZ, flagP}) == 1);
  // R8: flags follow the written value
  a_r8_flag_value: assert property (@(posedge clk) disable iff (!rstN)
    strobes.regWrite |=> (flagN == $past(regData[WORD_W-1])) &&
                         (flagZ == ($past(regData) == '0)));
  // R7: flags hold when nothing is written back
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.regWrite |=> $stable({flagN, flagZ, flagP}));
endmodule

// File: rtl/ldst_seq.sv
`timescale 1ns/1ps
module ldst_seq
  import ldst_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] pcNext,
  input  logic [WORD_W-1:0] baseVal,
  input  logic [WORD_W-1:0] srcVal,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              memRd,
  output logic              memWr,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memReady,
  output logic              regWe,
  output logic [IDX_W-1:0]  regIdx,
  output logic [WORD_W-1:0] regData,
  output logic              flagN,
  output logic              flagZ,
  output logic              flagP,
  output logic              done
);
  ctrlStrobes_t strobes;

  ldst_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .opcode   (instr[WORD_W-1 -: OP_W]),
    .memReady (memReady),
    .strobes  (strobes)
  );

  ldst_dpath #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .instr    (instr),
    .pcNext   (pcNext),
    .baseVal  (baseVal),
    .srcVal   (srcVal),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .regIdx   (regIdx),
    .regData  (regData),
    .flagN    (flagN),
    .flagZ    (flagZ),
    .flagP    (flagP)
  );

  assign memRd = strobes.rdStb;
  assign memWr = strobes.wrStb;
  assign regWe = strobes.regWrite;
  assign done  = strobes.doneStb;

  // R9: an access waiting for ready holds its address, data and strobe
  a_r9_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memRd || memWr) && !memReady |=>
      (memRd == $past(memRd)) && (memWr == $past(memWr)) &&
      $stable(memAddr) && $stable(memWdata));
  // R10: no register write while memory is strobed
  a_r10_wb_no_access: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> !(memRd || memWr));
endmodule

// File: tb/ldst_seq_test.sv
`timescale 1ns/1ps
module ldst_seq_test;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [15:0] instr = '0, pcNext = '0, baseVal = '0, srcVal = '0;
  logic [15:0] memAddr, memWdata, memRdata = '0, regData;
  logic memRd, memWr, memReady = 1'b0, regWe, flagN, flagZ, flagP, done;
  logic [2:0] regIdx;

  ldst_seq uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [15:0] wmem [int];
  function automatic logic [15:0] memRead(input logic [15:0] a);
    logic [31:0] h;
    if (wmem.exists(int'(a))) return wmem[int'(a)];
    h = {16'h0, a} * 32'h9e37;
    return h[15:0] ^ 16'h3c5a;
  endfunction

  // memory model and monitor (all at negedge)
  int accCount, wbCount, doneCount, rdCount, waitCnt;
  logic [15:0] rdAddr [2];
  logic [15:0] wrAddr, wbData;
  logic [2:0]  wbIdx;
  always @(negedge clk) begin
    if (!rstN) begin
      memReady = 0; waitCnt = 0;
    end else begin
      if (regWe) begin wbCount++; wbIdx = regIdx; wbData = regData; end
      if (done) doneCount++;
      if (memReady) memReady = 0;
      else if (memRd || memWr) begin
        if (waitCnt == 0) begin
          memReady = 1; accCount++;
          if (memWr) begin wmem[int'(memAddr)] = memWdata; wrAddr = memAddr; end
          else begin
            if (rdCount < 2) rdAddr[rdCount] = memAddr;
            rdCount++;
            memRdata = memRead(memAddr);
          end
          waitCnt = $urandom % 3;
        end else waitCnt--;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  bit eN = 0, eZ = 1, eP = 0;

  task automatic runInstr(input logic [15:0] ins, input logic [15:0] pc,
                          input logic [15:0] base, input logic [15:0] src,
                          input bit poke);
    logic [3:0] op = ins[15:12];
    logic [15:0] ea, ptr, target, data;
    int expAcc = 0, lat;
    bit expWb = 0, isStore = 0, isLoadRd = 0;
    string aTag;
    bit useBase = (op == 4'b0110) || (op == 4'b0111);
    aTag = useBase ? "R3" : "R2";
    ea = useBase ? base + {{10{ins[5]}}, ins[5:0]} : pc + {{7{ins[8]}}, ins[8:0]};
    ptr = memRead(ea); target = ea; data = 0;
    case (op)
      4'b0010, 4'b0110: begin data = memRead(ea); expAcc = 1; expWb = 1; isLoadRd = 1; end
      4'b1010: begin data = memRead(ptr); expAcc = 2; expWb = 1; isLoadRd = 1; end
      4'b1110: begin data = ea; expWb = 1; end
      4'b0011, 4'b0111: begin expAcc = 1; isStore = 1; end
      4'b1011: begin target = ptr; expAcc = 2; isStore = 1; isLoadRd = 1; end
      default: ;
    endcase
    accCount = 0; wbCount = 0; doneCount = 0; rdCount = 0;
    @(negedge clk);
    instr = ins; pcNext = pc; baseVal = base; srcVal = src; start = 1;
    @(negedge clk);
    start = 0; lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk); lat++;
      if (poke && lat == 2) begin start = 1; instr = 16'hE5FF; pcNext = 16'h1111; end
      if (poke && lat == 3) start = 0;
    end
    @(negedge clk); #1;
    check(lat < 200, "R10", "completion", 16'(lat), 0);
    check(doneCount == 1 && !done, "R10", "done pulse count", 16'(doneCount), 1);
    check(accCount == expAcc, (op == 4'b1010 || op == 4'b1011) ? "R4" : "R5",
          "access count", 16'(accCount), 16'(expAcc));
    check(wbCount == int'(expWb), isStore ? "R7" : "R6", "write-back count",
          16'(wbCount), 16'(expWb));
    if (expWb) begin
      check(wbIdx == ins[11:9], aTag, "dest index", 16'(wbIdx), 16'(ins[11:9]));
      check(wbData == data, poke ? "R11" : (op == 4'b1110 ? "R5" : "R6"),
            "write-back value", wbData, data);
      eN = data[15]; eZ = (data == 0); eP = !data[15] && data != 0;
    end
    check({flagN, flagZ, flagP} == {eN, eZ, eP}, expWb ? "R8" : "R7", "flags",
          16'({flagN, flagZ, flagP}), 16'({eN, eZ, eP}));
    if (isLoadRd) check(rdAddr[0] == ea, aTag, "first read address", rdAddr[0], ea);
    if (op == 4'b1010) check(rdAddr[1] == ptr, "R4", "operand address", rdAddr[1], ptr);
    if (isStore) begin
      check(wrAddr == target, op == 4'b1011 ? "R4" : aTag, "write address", wrAddr, target);
      check(memRead(target) == src, "R7", "stored value", memRead(target), src);
    end
    if (op == 4'b1110) check(lat == 2, "R5", "address-only latency", 16'(lat), 2);
    if (expAcc == 0 && !expWb) check(lat == 1, "R10", "other opcode latency", 16'(lat), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    // R1 reset state
    check(!memRd && !memWr && !regWe && !done, "R1", "strobes idle",
          16'({memRd, memWr, regWe, done}), 0);
    check({flagN, flagZ, flagP} == 3'b010, "R1", "reset flags",
          16'({flagN, flagZ, flagP}), 16'h2);
    // directed corners
    runInstr(16'hE1FF, 16'h0001, 0, 0, 0);          // R5 address-only to zero
    runInstr(16'h3500, 16'h4000, 0, 16'h0000, 0);   // R2 store 0, max negative disp
    runInstr(16'h2700, 16'h4000, 0, 0, 0);          // R2 load it back -> Z
    runInstr(16'h7A60, 0, 16'h1000, 16'h8001, 0);   // R3 disp -32
    runInstr(16'h6C60, 0, 16'h1000, 0, 0);          // R3 load negative
    runInstr(16'h7A5F, 0, 16'h2000, 16'h0123, 0);   // R3 disp +31
    runInstr(16'h6C5F, 0, 16'h2000, 0, 0);
    runInstr(16'h3AFF, 16'h5000, 0, 16'h6000, 0);   // pointer cell -> 0x6000
    runInstr(16'hB4FF, 16'h5000, 0, 16'h7777, 0);   // R4 indirect store
    runInstr(16'hA6FF, 16'h5000, 0, 0, 0);          // R4 indirect load
    runInstr(16'hA6FF, 16'h5000, 0, 0, 1);          // R11 start while busy
    runInstr(16'h1234, 16'h5000, 0, 0, 0);          // R10 other opcode
    for (int i = 0; i < 400; i++) begin
      logic [3:0] ops [8] = '{4'b0010, 4'b1010, 4'b0110, 4'b1110,
                              4'b0011, 4'b1011, 4'b0111, 4'b0101};
      logic [15:0] src = ($urandom % 5 == 0) ? 16'h0 : 16'($urandom);
      runInstr({ops[$urandom % 8], 12'($urandom)}, 16'($urandom), 16'($urandom),
               src, 0);
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule